// File: doc/BRIEF.md
# Fair Tree Arbiter for Event Requests

This block settles contention among N event sources that share one output channel. Each source raises a request line and keeps it high until it sees its own acknowledge bit. It then drops the request. The arbiter answers with a registered acknowledge vector that has at most one bit set.

Inside, the block is a binary tree of two-input decision cells. A cell passes the OR of its two inputs up to its parent. It steers a grant coming down from the parent to exactly one of its requesting children. The tree has N-1 cells and log2(N) levels.

The `POLICY` parameter picks how every cell breaks a tie:

- **Fixed policy:** the cell always prefers its lower input.
- **Fair policy:** the cell keeps a one-bit preference. It inverts that bit each time a grant passes through it, so fairness is settled locally at every level of the tree.

A grant stays latched until its requester withdraws. While a grant is out, no other grant is issued. One idle cycle always separates consecutive grants.

Top module: `evt_tree_arb`

## Requirements
- R1: While `rst` is high, `ack` is all zero on the next clock edge. Every cell's preference returns to its lower input, so after reset a tie between inputs 0 and 1 under the fair policy goes to input 0.
- R2: `ack` is always either zero or one-hot, where bit i acknowledges `req[i]`.
- R3: When `ack` is zero and `req` is non-zero at a clock edge, `ack` is non-zero after that edge. The set bit is one that was requested at that edge, giving one cycle of latency.
- R4: While the acknowledged request stays high, `ack` holds its value, whatever the other request lines do.
- R5: When the acknowledged request is low at a clock edge, `ack` becomes zero after that edge. A new grant can appear at the earliest one edge later.
- R6: With `POLICY` set to fixed, a new grant always goes to the lowest-index active request.
- R7: With `POLICY` set to fair, every cell that a grant passes through inverts its preference bit. A set preference bit means the upper child wins a tie. With N=8 and all eight inputs contending from a cell state that is known, each input is served exactly once, in the order this rule produces.
- R8: Under the fair policy, two inputs that share a leaf cell and re-request immediately after each grant are served alternately.
- R9: With no request active and no grant outstanding, `ack` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N | Request lines, one per event source |
| ack | output | N | Registered acknowledge vector, zero or one-hot |

## Verification
Timing of results relative to a stimulus:

- A request presented to an idle arbiter is acknowledged after exactly one rising edge.
- Withdrawing the acknowledged request clears `ack` one edge later.
- The next grant follows one edge after that.

The bench drives inputs on the falling edge and samples on the next falling edge. Each sample therefore sees the result of exactly one rising edge. The requester model in the bench drops a request on the sample where its acknowledge appears, as a real source would. It re-asserts persistent requests only on a sample where `ack` is zero.

Grant orders are predicted by hand from the preference-bit rule. They are compared one grant at a time for the fair and fixed instances, which run side by side.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;

  // Tie-break policy applied by every two-input cell of the tree.
  typedef enum logic {
    POL_FIXED = 1'b0,
    POL_FAIR  = 1'b1
  } arb_policy_e;

endpackage

// File: rtl/evt_arb_cell.sv
// Two-input decision cell. Requests flow up as an OR, a grant flows down to
// exactly one requesting child. Under the fair policy the preference bit
// inverts on every grant that passes through this cell.
module evt_arb_cell #(
  parameter evt_arb_pkg::arb_policy_e POLICY = evt_arb_pkg::POL_FAIR
) (
  input  logic clk,
  input  logic rst,
  input  logic req_lo,
  input  logic req_hi,
  input  logic gnt_in,
  output logic any_req,
  output logic gnt_lo,
  output logic gnt_hi
);

  localparam logic TOGGLE_EN = (POLICY == evt_arb_pkg::POL_FAIR);

  logic favor_hi;
  logic pick_lo;

  assign any_req = req_lo | req_hi;

  // Lower child wins if it requests alone, or on a tie when not favouring hi.
  always_comb begin
    pick_lo = req_lo & (~req_hi | ~favor_hi);
  end

  assign gnt_lo = gnt_in & pick_lo;
  assign gnt_hi = gnt_in & ~pick_lo & req_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      favor_hi <= 1'b0;
    end else if (TOGGLE_EN && gnt_in && any_req) begin
      favor_hi <= ~favor_hi;
    end
  end

endmodule

// File: rtl/evt_arb_tree.sv
// Heap-indexed tree of N-1 cells. Node 1 is the root, node k has children
// 2k and 2k+1, leaves are nodes N..2N-1 carrying request i at node N+i.
module evt_arb_tree #(
  parameter int unsigned N = 8,
  parameter evt_arb_pkg::arb_policy_e POLICY = evt_arb_pkg::POL_FAIR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         issue,
  output logic [N-1:0] pick,
  output logic         any_req
);

  localparam int unsigned NODES = 2 * N;

  logic node_req [1:NODES-1];
  logic node_gnt [1:NODES-1];

  assign node_gnt[1] = issue;
  assign any_req     = node_req[1];

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_leaf
      assign node_req[N + gi] = req[gi];
      assign pick[gi]         = node_gnt[N + gi];
    end

    for (gi = 1; gi < N; gi++) begin : g_cell
      evt_arb_cell #(.POLICY(POLICY)) u_cell (
        .clk     (clk),
        .rst     (rst),
        .req_lo  (node_req[2*gi]),
        .req_hi  (node_req[2*gi+1]),
        .gnt_in  (node_gnt[gi]),
        .any_req (node_req[gi]),
        .gnt_lo  (node_gnt[2*gi]),
        .gnt_hi  (node_gnt[2*gi+1])
      );
    end
  endgenerate

endmodule

// File: rtl/evt_arb_hold.sv
// Grant register: loads the tree pick when idle, holds it while the granted
// request stays high, clears it once that request is withdrawn.
module evt_arb_hold #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] pick,
  output logic [N-1:0] ack,
  output logic         idle
);

  logic [N-1:0] ack_q;

  assign idle = (ack_q == '0);
  assign ack  = ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= '0;
    end else if (idle) begin
      ack_q <= pick;
    end else if ((ack_q & req) == '0) begin
      ack_q <= '0;
    end
  end

endmodule

// File: rtl/evt_tree_arb.sv
module evt_tree_arb #(
  parameter int unsigned N = 8,
  parameter evt_arb_pkg::arb_policy_e POLICY = evt_arb_pkg::POL_FAIR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] ack
);

  logic [N-1:0] pick;
  logic         any_req;
  logic         idle;
  logic         issue;

  // A grant is only sent down the tree when nothing is outstanding.
  assign issue = idle & any_req;

  evt_arb_tree #(.N(N), .POLICY(POLICY)) u_tree (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .issue   (issue),
    .pick    (pick),
    .any_req (any_req)
  );

  evt_arb_hold #(.N(N)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .pick (pick),
    .ack  (ack),
    .idle (idle)
  );

endmodule

// File: rtl/evt_tree_arb_chk.sv
module evt_tree_arb_chk #(
  parameter int unsigned N = 8,
  parameter evt_arb_pkg::arb_policy_e POLICY = evt_arb_pkg::POL_FAIR
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic [N-1:0] ack
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (ack == '0));

  assert_onehot_ack_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack));

  assert_grant_follows_req_R3: assert property (@(posedge clk) disable iff (rst)
    (ack == '0 && req != '0) |=> (ack != '0));

  assert_grant_was_requested_R3: assert property (@(posedge clk) disable iff (rst)
    (ack == '0) |=> ((ack & ~$past(req)) == '0));

  assert_grant_held_R4: assert property (@(posedge clk) disable iff (rst)
    (ack != '0 && (ack & req) != '0) |=> $stable(ack));

  assert_release_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (ack != '0 && (ack & req) == '0) |=> (ack == '0));

  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (rst)
    (ack == '0 && req == '0) |=> (ack == '0));

  generate
    if (POLICY == evt_arb_pkg::POL_FIXED) begin : g_fixed
      assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (ack == '0 && req != '0) |=>
          (ack == ($past(req) & (~$past(req) + 1'b1))));
    end
  endgenerate

endmodule

bind evt_tree_arb evt_tree_arb_chk #(.N(N), .POLICY(POLICY)) u_chk (
  .clk (clk),
  .rst (rst),
  .req (req),
  .ack (ack)
);

// File: tb/evt_tree_arb_tb.sv
module evt_tree_arb_tb;

  localparam int unsigned N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_a = '0;
  logic [N-1:0] req_b = '0;
  logic [N-1:0] ack_a;
  logic [N-1:0] ack_b;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  evt_tree_arb #(.N(N), .POLICY(evt_arb_pkg::POL_FAIR)) u_dut (
    .clk (clk), .rst (rst), .req (req_a), .ack (ack_a)
  );

  evt_tree_arb #(.N(N), .POLICY(evt_arb_pkg::POL_FIXED)) u_fix (
    .clk (clk), .rst (rst), .req (req_b), .ack (ack_b)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic test_reset();
    rst = 1'b1; req_a = '0; req_b = '0;
    repeat (2) @(negedge clk);
    chk(ack_a == '0, "R1 reset fair", ack_a, '0);
    chk(ack_b == '0, "R1 reset fixed", ack_b, '0);
    rst = 1'b0;
  endtask

  task automatic test_idle();
    repeat (3) @(negedge clk);
    chk(ack_a == '0, "R9 idle fair", ack_a, '0);
    chk(ack_b == '0, "R9 idle fixed", ack_b, '0);
  endtask

  task automatic test_single_hold();
    req_a = 8'h10; req_b = 8'h10;
    @(negedge clk);
    chk(ack_a == 8'h10, "R3 single fair", ack_a, 8'h10);
    chk(ack_b == 8'h10, "R3 single fixed", ack_b, 8'h10);
    req_a = 8'h11; req_b = 8'h11;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(ack_a == 8'h10, "R4 hold fair", ack_a, 8'h10);
      chk(ack_b == 8'h10, "R4 hold fixed", ack_b, 8'h10);
    end
    req_a = 8'h01; req_b = 8'h01;
    @(negedge clk);
    chk(ack_a == '0, "R5 release fair", ack_a, '0);
    chk(ack_b == '0, "R5 release fixed", ack_b, '0);
    @(negedge clk);
    chk(ack_a == 8'h01, "R5 next grant fair", ack_a, 8'h01);
    chk(ack_b == 8'h01, "R5 next grant fixed", ack_b, 8'h01);
    req_a = '0; req_b = '0;
    @(negedge clk);
  endtask

  // All eight inputs contend; each requester drops when acknowledged.
  task automatic test_full_contention();
    int exp_fair [8] = '{2, 6, 1, 5, 3, 7, 0, 4};
    int got_a [8];
    int got_b [8];
    int na = 0;
    int nb = 0;
    req_a = '1; req_b = '1;
    for (int c = 0; c < 40 && (na < 8 || nb < 8); c++) begin
      @(negedge clk);
      chk($onehot0(ack_a), "R2 onehot fair", ack_a, '0);
      chk($onehot0(ack_b), "R2 onehot fixed", ack_b, '0);
      if (ack_a != '0 && na < 8) begin
        got_a[na] = idx_of(ack_a); na++; req_a = req_a & ~ack_a;
      end
      if (ack_b != '0 && nb < 8) begin
        got_b[nb] = idx_of(ack_b); nb++; req_b = req_b & ~ack_b;
      end
    end
    for (int k = 0; k < 8; k++) begin
      chk(na > k && got_a[k] == exp_fair[k], "R7 fair order",
          N'(got_a[k]), N'(exp_fair[k]));
      chk(nb > k && got_b[k] == k, "R6 fixed order", N'(got_b[k]), N'(k));
    end
    req_a = '0; req_b = '0;
    repeat (2) @(negedge clk);
  endtask

  // Inputs 0 and 1 re-request as soon as the grant has cleared.
  task automatic test_pair_alternate();
    int exp_fair [4] = '{1, 0, 1, 0};
    int got_a [4];
    int got_b [4];
    int na = 0;
    int nb = 0;
    req_a = 8'h03; req_b = 8'h03;
    for (int c = 0; c < 30 && (na < 4 || nb < 4); c++) begin
      @(negedge clk);
      if (ack_a != '0) begin
        if (na < 4) begin got_a[na] = idx_of(ack_a); na++; end
        req_a = req_a & ~ack_a;
      end else if (na < 4) begin
        req_a = req_a | 8'h03;
      end
      if (ack_b != '0) begin
        if (nb < 4) begin got_b[nb] = idx_of(ack_b); nb++; end
        req_b = req_b & ~ack_b;
      end else if (nb < 4) begin
        req_b = req_b | 8'h03;
      end
    end
    for (int k = 0; k < 4; k++) begin
      chk(na > k && got_a[k] == exp_fair[k], "R8 fair alternate",
          N'(got_a[k]), N'(exp_fair[k]));
      chk(nb > k && got_b[k] == 0, "R6 fixed pair", N'(got_b[k]), N'(0));
    end
    req_a = '0; req_b = '0;
    repeat (2) @(negedge clk);
  endtask

  // Reset while a grant is out; preferences must return to the lower input.
  task automatic test_reset_midgrant();
    req_a = 8'h40; req_b = 8'h40;
    @(negedge clk);
    chk(ack_a == 8'h40, "R3 grant before reset", ack_a, 8'h40);
    rst = 1'b1; req_a = '0; req_b = '0;
    @(negedge clk);
    chk(ack_a == '0, "R1 mid-grant reset fair", ack_a, '0);
    chk(ack_b == '0, "R1 mid-grant reset fixed", ack_b, '0);
    rst = 1'b0; req_a = 8'h03; req_b = 8'h03;
    @(negedge clk);
    chk(ack_a == 8'h01, "R1 preference reset fair", ack_a, 8'h01);
    chk(ack_b == 8'h01, "R6 lowest after reset", ack_b, 8'h01);
    req_a = '0; req_b = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    test_reset();
    test_idle();
    test_single_hold();
    test_full_contention();
    test_pair_alternate();
    test_reset_midgrant();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule